// File: doc/BRIEF.md
# Five-Word Add-Rotate-XOR Block Update with Keystream History

This block advances a stream cipher state of five 32-bit words by one block. A block runs a fixed half-block mixing function twice. Each run is a chain of ten add-or-XOR steps, and each step is followed by a constant left rotation. The first run is keyed by one pair of 32-bit subkeys and the second run by another pair. All four subkeys arrive on input ports together with the five state words. They are captured when a start strobe is accepted, so the driver may change them after the start cycle.

The design shares a single 32-bit adder between all steps and performs one step per clock cycle. A block therefore always takes twenty cycles after the start edge. The block also holds a four-deep history of the word-4 values that entered earlier blocks. The keystream word of the current block is the sum of the word-4 value reached after the first half and the oldest history entry. The first eight blocks after reset form a warm-up phase: their keystream is computed but is not flagged as valid. A caller chains blocks by feeding the updated words back in with fresh subkeys.

Top module: `sc_block_update`

## Requirements
- R1: A synchronous reset that is active high clears the updated-word outputs, the keystream output, `ksValid`, `done`, the word-4 history and the block counter. A reset that arrives in the middle of a block abandons that block.
- R2: A `start` that is sampled while the block is idle captures `inW0`..`inW4` and `key0`..`key3`. `done` then rises exactly 20 clock edges after that capturing edge, and never earlier.
- R3: The first half uses `key0` where the first subkey enters, at step 1, as `w0 += (w3 ^ K)`. It uses `key1` where the second subkey enters, at step 6, as `w0 ^= (w3 + K)`. The second half uses `key2` and `key3` at the same two points.
- R4: Each half runs ten steps in order. Steps 1 to 5 are: w0+=(w3^Ka), rotl w3 by 15; w1+=w4, rotl w4 by 25; w2^=w0, rotl w0 by 9; w3^=w1, rotl w1 by 10; w4+=w2, rotl w2 by 17. Steps 6 to 10 are: w0^=(w3+Kb), rotl w3 by 30; w1^=w4, rotl w4 by 13; w2+=w0, rotl w0 by 20; w3+=w1, rotl w1 by 11; w4^=w2, rotl w2 by 5. Addition is modulo 2^32. While `done` is high, `outW0`..`outW4` hold the result of both halves.
- R5: While `done` is high, `keystream` equals word 4 after the first half plus the `inW4` value captured four blocks earlier, modulo 2^32. The history entry counts as zero if fewer than four blocks have completed since reset.
- R6: `ksValid` stays low for the first eight blocks that complete after reset. It is high with `done` for every later block.
- R7: A `start` that arrives while a block is running is ignored. The running block's result and its completion cycle do not change.
- R8: `done` is high for exactly one cycle per block. `ksValid` is never high while `done` is low.
- R9: While idle with `start` low, `outW0`..`outW4` keep their values whatever the data and key inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a block; sampled only while idle |
| inW0 | input | 32 | State word 0 in |
| inW1 | input | 32 | State word 1 in |
| inW2 | input | 32 | State word 2 in |
| inW3 | input | 32 | State word 3 in |
| inW4 | input | 32 | State word 4 in |
| key0 | input | 32 | First-half subkey at step 1 |
| key1 | input | 32 | First-half subkey at step 6 |
| key2 | input | 32 | Second-half subkey at step 1 |
| key3 | input | 32 | Second-half subkey at step 6 |
| outW0 | output | 32 | Updated state word 0 |
| outW1 | output | 32 | Updated state word 1 |
| outW2 | output | 32 | Updated state word 2 |
| outW3 | output | 32 | Updated state word 3 |
| outW4 | output | 32 | Updated state word 4 |
| keystream | output | 32 | Keystream word of the last block |
| ksValid | output | 1 | Keystream word is past warm-up |
| done | output | 1 | One-cycle block completion pulse |

## Verification
The block is driven with several kinds of state and subkey patterns, each chosen to expose a different fault:
- **All zeros:** must map to zero. Any wrong constant or stray injection shows up at once.
- **All ones and repeated top-bit words:** carries run out of every adder, which exposes a missing wrap modulo 2^32.
- **A single set bit in word 0:** follows one rotation chain and reveals a wrong rotation amount or a wrong step order.
- **Zero state with only subkeys set:** shows whether each subkey enters at its own step and in its own half.

Twelve chained blocks cover the boundary of the eight-block warm-up and the four-block delay of the history. A start pulse during a running block and a reset in the middle of a block close the set.

// File: rtl/sc_blk_pkg.sv
package sc_blk_pkg;

  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 5;
  localparam int NUM_KEYS    = 4;
  localparam int HALF_STEPS  = 10;
  localparam int BLOCK_STEPS = 2 * HALF_STEPS;
  localparam int STEP_W      = $clog2(BLOCK_STEPS);

  typedef logic [WORD_W-1:0] word_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic              load;     // capture inputs
    logic              step;     // perform one mixing step
    logic [STEP_W-1:0] stepIdx;  // 0..BLOCK_STEPS-1
    logic              midCap;   // last step of first half
    logic              finish;   // last step of block
  } blkCtrl_t;

  // rotation applied to the source word after step j of a half
  function automatic int rotAmt(input int j);
    case (j)
      0:       return 15;
      1:       return 25;
      2:       return 9;
      3:       return 10;
      4:       return 17;
      5:       return 30;
      6:       return 13;
      7:       return 20;
      8:       return 11;
      default: return 5;
    endcase
  endfunction

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

endpackage

// File: rtl/sc_blk_ctrl.sv
module sc_blk_ctrl
  import sc_blk_pkg::*;
#(
  parameter int INIT_BLOCKS = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output blkCtrl_t ctrl,
  output logic     busy,
  output logic     done,
  output logic     ksValid
);

  localparam int CNT_W = $clog2(INIT_BLOCKS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BLOCK_STEPS - 1);
  localparam logic [STEP_W-1:0] MID_STEP  = STEP_W'(HALF_STEPS - 1);
  localparam logic [CNT_W-1:0]  CNT_LIM   = CNT_W'(INIT_BLOCKS);

  logic [STEP_W-1:0] stepCnt;
  logic [CNT_W-1:0]  blkCnt;

  always_comb begin
    ctrl.load    = !busy && start;
    ctrl.step    = busy;
    ctrl.stepIdx = stepCnt;
    ctrl.midCap  = busy && (stepCnt == MID_STEP);
    ctrl.finish  = busy && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      blkCnt  <= '0;
      done    <= 1'b0;
      ksValid <= 1'b0;
    end else begin
      done    <= 1'b0;
      ksValid <= 1'b0;
      if (!busy && start) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == LAST_STEP) begin
          busy    <= 1'b0;
          stepCnt <= '0;
          done    <= 1'b1;
          ksValid <= (blkCnt >= CNT_LIM);
          if (blkCnt < CNT_LIM) blkCnt <= blkCnt + 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sc_blk_dpath.sv
module sc_blk_dpath
  import sc_blk_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  blkCtrl_t                   ctrl,
  input  word_t [NUM_WORDS-1:0]      inWords,
  input  word_t [NUM_KEYS-1:0]       inKeys,
  output word_t [NUM_WORDS-1:0]      stateOut,
  output word_t                      keystream
);

  word_t [NUM_WORDS-1:0] st;
  word_t [NUM_WORDS-1:0] nx;
  word_t [NUM_KEYS-1:0]  keyReg;
  word_t                 inW4Reg;
  word_t                 midW4;
  word_t                 ksReg;
  word_t                 hist [FIFO_DEPTH];

  logic  secondHalf;
  int    j, tgt, src;
  word_t kA, kB, curT, curS, addA, addB, sum, res, rotV;

  // one step: target word gets add/xor, source word is rotated afterwards
  always_comb begin
    secondHalf = (ctrl.stepIdx >= STEP_W'(HALF_STEPS));
    j   = secondHalf ? int'(ctrl.stepIdx) - HALF_STEPS : int'(ctrl.stepIdx);
    tgt = (j >= 5) ? j - 5 : j;
    src = (tgt < 2) ? tgt + 3 : tgt - 2;
    kA  = secondHalf ? keyReg[2] : keyReg[0];
    kB  = secondHalf ? keyReg[3] : keyReg[1];
    curT = '0;
    curS = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (i == tgt) curT = st[i];
      if (i == src) curS = st[i];
    end
    // the single shared adder
    addA = (j == 5) ? curS : curT;
    addB = (j == 0) ? (curS ^ kA) : ((j == 5) ? kB : curS);
    sum  = addA + addB;
    case (j)
      0, 1, 4, 7, 8: res = sum;
      5:             res = curT ^ sum;
      default:       res = curT ^ curS;
    endcase
    rotV = rotl(curS, rotAmt(j));
    nx = st;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (i == tgt)      nx[i] = res;
      else if (i == src) nx[i] = rotV;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      keyReg  <= '0;
      inW4Reg <= '0;
      midW4   <= '0;
      ksReg   <= '0;
    end else if (ctrl.load) begin
      st      <= inWords;
      keyReg  <= inKeys;
      inW4Reg <= inWords[NUM_WORDS-1];
    end else if (ctrl.step) begin
      st <= nx;
      if (ctrl.midCap) midW4 <= nx[NUM_WORDS-1];
      if (ctrl.finish) ksReg <= midW4 + hist[FIFO_DEPTH-1];
    end
  end

  // history of captured word 4, shifted once per finished block
  for (genvar g = 0; g < FIFO_DEPTH; g++) begin : gHist
    if (g == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (rst)              hist[g] <= '0;
        else if (ctrl.finish) hist[g] <= inW4Reg;
      end
    end else begin : gTail
      always_ff @(posedge clk) begin
        if (rst)              hist[g] <= '0;
        else if (ctrl.finish) hist[g] <= hist[g-1];
      end
    end
  end

  assign stateOut  = st;
  assign keystream = ksReg;

endmodule

// File: rtl/sc_block_update.sv
module sc_block_update
  import sc_blk_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int INIT_BLOCKS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] inW0,
  input  logic [31:0] inW1,
  input  logic [31:0] inW2,
  input  logic [31:0] inW3,
  input  logic [31:0] inW4,
  input  logic [31:0] key0,
  input  logic [31:0] key1,
  input  logic [31:0] key2,
  input  logic [31:0] key3,
  output logic [31:0] outW0,
  output logic [31:0] outW1,
  output logic [31:0] outW2,
  output logic [31:0] outW3,
  output logic [31:0] outW4,
  output logic [31:0] keystream,
  output logic        ksValid,
  output logic        done
);

  blkCtrl_t              ctrl;
  logic                  busy;
  word_t [NUM_WORDS-1:0] stateOut;

  sc_blk_ctrl #(.INIT_BLOCKS(INIT_BLOCKS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done),
    .ksValid (ksValid)
  );

  sc_blk_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .inWords   ({inW4, inW3, inW2, inW1, inW0}),
    .inKeys    ({key3, key2, key1, key0}),
    .stateOut  (stateOut),
    .keystream (keystream)
  );

  assign outW0 = stateOut[0];
  assign outW1 = stateOut[1];
  assign outW2 = stateOut[2];
  assign outW3 = stateOut[3];
  assign outW4 = stateOut[4];

endmodule

// File: rtl/sc_block_update_chk.sv
module sc_block_update_chk
  import sc_blk_pkg::*;
#(
  parameter int INIT_BLOCKS = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        ksValid,
  input logic [31:0] keystream,
  input logic [31:0] outW0,
  input logic [31:0] outW4
);

  localparam int SEEN_W = $clog2(INIT_BLOCKS + 1);

  logic [STEP_W:0]   sinceStart;
  logic [SEEN_W-1:0] doneSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceStart <= '0;
      doneSeen   <= '0;
    end else begin
      if (start && !busy)       sinceStart <= 1;
      else if (done)            sinceStart <= '0;
      else if (sinceStart != 0) sinceStart <= sinceStart + 1'b1;
      if (done && doneSeen < SEEN_W'(INIT_BLOCKS)) doneSeen <= doneSeen + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !ksValid && keystream == '0 && outW0 == '0 && outW4 == '0));

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(sinceStart) == BLOCK_STEPS + 1));

  assert_warmup_R6: assert property (@(posedge clk) disable iff (rst)
    ksValid |-> (int'(doneSeen) >= INIT_BLOCKS));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_valid_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    ksValid |-> done);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(outW0) && $stable(outW4)));

endmodule

bind sc_block_update sc_block_update_chk #(.INIT_BLOCKS(INIT_BLOCKS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ksValid   (ksValid),
  .keystream (keystream),
  .outW0     (outW0),
  .outW4     (outW4)
);

// File: tb/sc_block_update_tb.sv
module sc_block_update_tb_top;

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3, w4, k0, k1, k2, k3;
  } vec_t;

  // stimulus patterns; expected results come from the reference model below
  localparam vec_t VECS [6] = '{
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
      32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h11111111, 32'h22222222, 32'h44444444, 32'h88888888},
    '{32'h01234567, 32'h89ABCDEF, 32'hDEADBEEF, 32'hCAFEF00D, 32'h0BADC0DE,
      32'h13579BDF, 32'h2468ACE0, 32'hF0E1D2C3, 32'h5A5AA5A5},
    '{32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000,
      32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000}
  };

  logic        clk = 1'b0;
  logic        rst, start;
  logic [31:0] inW0, inW1, inW2, inW3, inW4, key0, key1, key2, key3;
  logic [31:0] outW0, outW1, outW2, outW3, outW4, keystream;
  logic        ksValid, done;

  int          checks = 0;
  int          errors = 0;
  logic [31:0] mFifo [4];
  int          mCnt;
  logic [159:0] lastFin;

  always #10 clk = ~clk;

  sc_block_update dut_i (
    .clk(clk), .rst(rst), .start(start),
    .inW0(inW0), .inW1(inW1), .inW2(inW2), .inW3(inW3), .inW4(inW4),
    .key0(key0), .key1(key1), .key2(key2), .key3(key3),
    .outW0(outW0), .outW1(outW1), .outW2(outW2), .outW3(outW3), .outW4(outW4),
    .keystream(keystream), .ksValid(ksValid), .done(done)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] refHalf(input logic [159:0] s, input logic [31:0] a, b);
    logic [31:0] x0, x1, x2, x3, x4;
    {x4, x3, x2, x1, x0} = s;
    x0 = x0 + (x3 ^ a); x3 = rl(x3, 15);
    x1 = x1 + x4;       x4 = rl(x4, 25);
    x2 = x2 ^ x0;       x0 = rl(x0, 9);
    x3 = x3 ^ x1;       x1 = rl(x1, 10);
    x4 = x4 + x2;       x2 = rl(x2, 17);
    x0 = x0 ^ (x3 + b); x3 = rl(x3, 30);
    x1 = x1 ^ x4;       x4 = rl(x4, 13);
    x2 = x2 + x0;       x0 = rl(x0, 20);
    x3 = x3 + x1;       x1 = rl(x1, 11);
    x4 = x4 ^ x2;       x2 = rl(x2, 5);
    return {x4, x3, x2, x1, x0};
  endfunction

  function automatic logic [159:0] outs();
    return {outW4, outW3, outW2, outW1, outW0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    inW0 = v.w0; inW1 = v.w1; inW2 = v.w2; inW3 = v.w3; inW4 = v.w4;
    key0 = v.k0; key1 = v.k1; key2 = v.k2; key3 = v.k3;
  endtask

  task automatic clearModel();
    for (int i = 0; i < 4; i++) mFifo[i] = '0;
    mCnt = 0;
  endtask

  task automatic runBlock(input vec_t v, input bit midStart, input string stateReq);
    logic [159:0] st, mid, fin;
    logic [31:0]  eKs;
    bit           eV, early;
    vec_t         alt;
    st  = {v.w4, v.w3, v.w2, v.w1, v.w0};
    mid = refHalf(st, v.k0, v.k1);
    fin = refHalf(mid, v.k2, v.k3);
    eKs = mid[159:128] + mFifo[3];
    eV  = (mCnt >= 8);
    for (int i = 3; i > 0; i--) mFifo[i] = mFifo[i-1];
    mFifo[0] = v.w4;
    if (mCnt < 8) mCnt++;
    alt = ~v;
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    early = 1'b0;
    for (int c = 1; c < 20; c++) begin
      if (midStart && c == 5) begin apply(alt); start = 1'b1; end
      if (midStart && c == 6) start = 1'b0;
      @(negedge clk);
      if (done) early = 1'b1;
    end
    chk(!early, "R2 done early", 160'(early), 160'(0));
    @(negedge clk);
    chk(done == 1'b1, "R2 done latency", 160'(done), 160'(1));
    chk(outs() == fin, stateReq, outs(), fin);
    chk(keystream == eKs, "R5 keystream", 160'(keystream), 160'(eKs));
    chk(ksValid == eV, "R6 ksValid", 160'(ksValid), 160'(eV));
    lastFin = fin;
    @(negedge clk);
    chk(!done && !ksValid, "R8 pulse width", {158'(0), done, ksValid}, 160'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    rst = 1'b1; start = 1'b0;
    apply(VECS[4]);
    clearModel();
    repeat (3) @(negedge clk);
    chk(outs() == '0 && keystream == '0 && !done && !ksValid, "R1 reset state",
        {outs()[127:0], keystream}, 160'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == '0 && !done, "R1 after release", outs(), 160'(0));

    // table walk: warm-up boundary at block 8, history delay of four blocks
    for (int i = 0; i < 12; i++) begin
      v = VECS[i % 6];
      if (i >= 6) v = v ^ {9{32'h9E3779B9 * 32'(i)}};
      // pattern 3 has a zero state and distinct subkeys: isolates key placement (R3)
      runBlock(v, 1'b0, (i % 6 == 3) ? "R3 subkey placement" : "R4 state update");
      if (i == 0) chk(outs() == '0, "R4 zero maps to zero", outs(), 160'(0));
    end

    // idle: inputs move, no start (R9)
    apply(VECS[1]);
    repeat (3) @(negedge clk);
    apply(VECS[2]);
    @(negedge clk);
    chk(outs() == lastFin, "R9 idle hold", outs(), lastFin);

    // start while running is ignored (R7)
    runBlock(VECS[4], 1'b1, "R7 start while busy");

    // reset in the middle of a block (R1)
    apply(VECS[5]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(outs() == '0 && keystream == '0 && !done && !ksValid, "R1 mid-block reset",
        {outs()[127:0], keystream}, 160'(0));
    rst = 1'b0;
    clearModel();
    repeat (25) @(negedge clk);
    chk(!done, "R1 abandoned block", 160'(done), 160'(0));
    // history and counter cleared: keystream uses zero history, ksValid low
    runBlock(VECS[4], 1'b0, "R1 first block after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule